// File: doc/BRIEF.md
# SPI Master Transmit Engine with Prefetch Buffer

This block drives an SPI bus as master. Software hands it bytes through a small register-write port. Each byte passes through two stages. The first is a holding buffer that software can see through the full and empty flags. The second is a shift register that drives MOSI, MSB first, in SPI mode 0. SCLK runs at the system clock divided by the fixed even ratio `CLK_DIV`. Each transfer also gathers one byte from MISO. That byte appears on `rx_data` when the transfer ends.

There are two ways to run the engine. In single-shot mode, software writes a byte and then writes the control register with the go bit set to start the transfer. Data writes are refused while a transfer is in progress. In buffered mode, hardware takes over the go/busy function. A byte that reaches an empty holding buffer starts a transfer by itself. Software may also write the next byte while the current one is still shifting. When a transfer finishes and a byte is waiting, the engine moves that byte into the shift register, holds a programmable idle gap, and then sends it. If nothing is waiting, the engine releases slave select and stops.

Top module: `spi_prefetch_master`

## Requirements
- R1: After reset the outputs read: `spi_ss_n`=1, `spi_sclk`=0, `spi_mosi`=0, `busy`=0, `tx_empty`=1, `tx_full`=0, `rx_data`=0.
- R2: A data write (`wr_addr`=0) to an empty holding buffer sets `tx_full`=1 and `tx_empty`=0 from the next cycle. A data write while `tx_full`=1 is ignored, and the held byte is sent unchanged.
- R3: With buffered mode off, a transfer starts only on a control write (`wr_addr`=1) with bit 0 (go) set, and only while the engine is idle with a byte held. `busy` is 1 in the cycle after that write. Data writes while `busy`=1 are ignored in this mode.
- R4: A transfer lasts 8 bit periods of `CLK_DIV` cycles each. `spi_ss_n` is low throughout. In each bit period SCLK is low for the first half and high for the second. MOSI carries the byte MSB first and is stable across each rising SCLK edge. SCLK is low whenever the engine is idle.
- R5: MISO is sampled on each rising SCLK edge, MSB first. The assembled byte appears on `rx_data` after the last bit period.
- R6: Control bit 1 enables buffered mode. If a byte is held when the mode is enabled, or a byte arrives while the engine is idle in this mode, the transfer starts one cycle after the write.
- R7: In buffered mode, a data write is accepted during a transfer and stays held (`tx_full`=1) until that transfer ends. At that point it moves to the shift register and `tx_full` clears.
- R8: Between chained transfers the engine idles for (N+2)*`CLK_DIV` cycles, where N is control bits [5:2]. During this gap `busy`=1, `spi_ss_n`=0 and `spi_sclk`=0. A chain of k bytes keeps `busy` high for k*8*`CLK_DIV` + (k-1)*(N+2)*`CLK_DIV` cycles.
- R9: In buffered mode, a transfer that ends with no byte held returns the engine to idle, with `busy`=0 and `spi_ss_n`=1.
- R10: In buffered mode the go bit has no effect. It does not restart or extend a running transfer, and it does not start a transfer when no byte is held.
- R11: Clearing buffered mode during a transfer stops the chain at the end of that transfer. A byte already held stays held (`tx_full`=1) until a go write sends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = transmit data, 1 = control (bit0 go, bit1 buffered, bits[5:2] gap N) |
| wr_data | input | DATA_W | Write data |
| tx_empty | output | 1 | Holding buffer vacant |
| tx_full | output | 1 | Holding buffer holds a byte not yet taken |
| busy | output | 1 | Transfer or inter-transfer gap in progress |
| rx_data | output | DATA_W | Byte received in the last transfer |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 1 | Slave select, active low |

## Verification
Some internal faults show at the pins within one bit period: a bit counter that wraps early or late, or a tick counter that is off by one. They change the SCLK pulse count or the MOSI bit order in the first byte. A gap counter that is loaded wrongly stays hidden until the second byte of a chain. It then shows as a wrong busy length and a late or early first SCLK edge. A holding-buffer flag that is out of step with its data shows either as a lost byte, when a chain stops early, or as a repeated byte, when a chain runs one transfer too many. Either appears at the next transfer boundary. The bench runs a reference model and compares every output on every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/spi_pf_pkg.sv
// Shared definitions for the SPI prefetch master: sequencer states and the
// layout of the write port's address and control word.
package spi_pf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } xfer_state_e;

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_BUF_BIT = 1;
    localparam int CTRL_GAP_LSB = 2;

endpackage

// File: rtl/spi_pf_regs.sv
// Holding buffer and control register of the SPI prefetch master.
// Accepts a data write only when the holding buffer is vacant, and (when
// buffered mode is off) only while the engine is idle. The go bit is not
// stored: it is passed on as a one-cycle strobe.
// Assumes DATA_W >= CTRL_GAP_LSB + GAP_W.
module spi_pf_regs
    import spi_pf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              busy_i,
    input  logic              take_i,
    output logic [DATA_W-1:0] hold_data_o,
    output logic              hold_full_o,
    output logic              buf_en_o,
    output logic [GAP_W-1:0]  gap_o,
    output logic              go_o
);

    logic [DATA_W-1:0] hold_data_q;
    logic              hold_full_q;
    logic              buf_en_q;
    logic [GAP_W-1:0]  gap_q;
    logic              data_wr;
    logic              ctrl_wr;
    logic              accept;

    // Decode the write port into data and control strobes.
    assign data_wr = wr_en_i && (wr_addr_i == ADDR_DATA);
    assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);
    assign accept  = data_wr && !hold_full_q && (buf_en_q || !busy_i);

    // Holding buffer: filled by an accepted write, emptied when the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full_q <= 1'b0;
            hold_data_q <= '0;
        end else if (take_i) begin
            hold_full_q <= 1'b0;
        end else if (accept) begin
            hold_full_q <= 1'b1;
            hold_data_q <= wr_data_i;
        end
    end

    // Control register: buffered-mode enable and suspend gap length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_en_q <= 1'b0;
            gap_q    <= '0;
        end else if (ctrl_wr) begin
            buf_en_q <= wr_data_i[CTRL_BUF_BIT];
            gap_q    <= wr_data_i[CTRL_GAP_LSB +: GAP_W];
        end
    end

    generate
        if (DATA_W > CTRL_GAP_LSB + GAP_W) begin : g_rsv
            logic rsv_unused;
            assign rsv_unused = ^wr_data_i[DATA_W-1:CTRL_GAP_LSB+GAP_W];
        end
    endgenerate

    assign hold_data_o = hold_data_q;
    assign hold_full_o = hold_full_q;
    assign buf_en_o    = buf_en_q;
    assign gap_o       = gap_q;
    assign go_o        = ctrl_wr && wr_data_i[CTRL_GO_BIT];

    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full_q && data_wr && !take_i) |=> $stable(hold_data_q)); // R2
    AST_TAKE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> hold_full_q); // R7
    AST_SINGLE_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_en_q && busy_i && data_wr && !take_i) |=> (hold_full_q == $past(hold_full_q))); // R3

endmodule

// File: rtl/spi_pf_seq.sv
// Transfer sequencer of the SPI prefetch master. Three states: idle, shifting
// and suspend gap. It counts system-clock ticks inside each bit period and bits
// inside each byte, and it issues strobes to the shifter for load, rising SCLK,
// falling SCLK and end of byte. It chains to the next byte when buffered mode
// is on and a byte is held.
// Assumes CLK_DIV is even and at least 2.
module spi_pf_seq
    import spi_pf_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 4,
    parameter int GAP_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_full_i,
    input  logic             buf_en_i,
    input  logic             go_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             take_o,
    output logic             rise_o,
    output logic             fall_o,
    output logic             done_o,
    output logic             active_o,
    output logic             shifting_o
);

    localparam int HALF   = CLK_DIV / 2;
    localparam int TICK_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W  = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam int GAPC_W = $clog2(((2 ** GAP_W) + 1) * CLK_DIV);

    xfer_state_e       state_q, state_d;
    logic [TICK_W-1:0] tick_q;
    logic [BIT_W-1:0]  bit_q;
    logic [GAPC_W-1:0] gap_cnt_q;
    logic              start_idle;
    logic              last_tick;
    logic              done;
    logic              chain;
    logic              gap_zero;

    // Event decode from the current state and counters.
    assign start_idle = (state_q == ST_IDLE) && hold_full_i && (buf_en_i || go_i);
    assign last_tick  = (state_q == ST_SHIFT) && (tick_q == TICK_W'(CLK_DIV - 1));
    assign done       = last_tick && (bit_q == BIT_W'(DATA_W - 1));
    assign chain      = done && buf_en_i && hold_full_i;
    assign gap_zero   = (gap_cnt_q == '0);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (start_idle) state_d = ST_SHIFT;
            ST_SHIFT: if (done)       state_d = chain ? ST_GAP : ST_IDLE;
            ST_GAP:   if (gap_zero)   state_d = ST_SHIFT;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Tick and bit counters: they run only while shifting and rest at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_SHIFT) begin
            tick_q <= '0;
            bit_q  <= '0;
        end else if (last_tick) begin
            tick_q <= '0;
            bit_q  <= done ? '0 : bit_q + 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    // Suspend gap counter: loaded on a chained end of byte, then counts down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt_q <= '0;
        end else if (chain) begin
            gap_cnt_q <= GAPC_W'((int'(gap_i) + 2) * CLK_DIV - 1);
        end else if (state_q == ST_GAP && !gap_zero) begin
            gap_cnt_q <= gap_cnt_q - 1'b1;
        end
    end

    assign take_o     = start_idle || chain;
    assign rise_o     = (state_q == ST_SHIFT) && (tick_q == TICK_W'(HALF - 1));
    assign fall_o     = last_tick;
    assign done_o     = done;
    assign active_o   = (state_q != ST_IDLE);
    assign shifting_o = (state_q == ST_SHIFT);

    AST_STOP_ONLY_WHEN_DRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_SHIFT) |-> $past(!(buf_en_i && hold_full_i))); // R9
    AST_GAP_ONLY_ON_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && $past(state_q) == ST_SHIFT) |-> $past(buf_en_i && hold_full_i)); // R8
    AST_NO_START_WITHOUT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !hold_full_i) |=> (state_q == ST_IDLE)); // R3

endmodule

// File: rtl/spi_pf_shifter.sv
// Serial data path of the SPI prefetch master: the transmit shift register, the
// SCLK phase flop and the receive shift register. It acts only on strobes from
// the sequencer. A load takes priority over a shift on the same edge.
// Assumes DATA_W >= 2.
module spi_pf_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              done_i,
    input  logic              active_i,
    input  logic              shifting_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic [DATA_W-1:0] rx_data_o
);

    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic [DATA_W-1:0] rx_data_q;
    logic              sclk_q;

    // Transmit shift register: load a new byte, or advance one bit at falling SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n)      tx_sh_q <= '0;
        else if (load_i) tx_sh_q <= load_data_i;
        else if (fall_i) tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
    end

    // SCLK phase: high from mid bit period until the end of the bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i || fall_i) sclk_q <= 1'b0;
        else if (rise_i)                sclk_q <= 1'b1;
    end

    // Receive path: sample MISO at each rising SCLK, publish the byte at end of byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh_q   <= '0;
            rx_data_q <= '0;
        end else begin
            if (rise_i) rx_sh_q   <= {rx_sh_q[DATA_W-2:0], miso_i};
            if (done_i) rx_data_q <= rx_sh_q;
        end
    end

    assign sclk_o    = sclk_q;
    assign mosi_o    = active_i && tx_sh_q[DATA_W-1];
    assign rx_data_o = rx_data_q;

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |-> !sclk_q); // R4
    AST_SCLK_LOW_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !shifting_i) |-> !sclk_q); // R8

endmodule

// File: rtl/spi_prefetch_master.sv
// Top level of the SPI master transmit engine with a prefetch holding buffer.
// It ties the register/holding-buffer stage, the transfer sequencer and the
// serial shifter together. Slave select is asserted while a transfer or an
// inter-transfer gap is in progress.
// Assumes a single clock domain, with MISO already synchronised to clk.
module spi_prefetch_master #(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 4,
    parameter int GAP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_empty,
    output logic              tx_full,
    output logic              busy,
    output logic [DATA_W-1:0] rx_data,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_ss_n
);

    logic [DATA_W-1:0] hold_data;
    logic              hold_full;
    logic              buf_en;
    logic [GAP_W-1:0]  gap_val;
    logic              go;
    logic              take;
    logic              rise;
    logic              fall;
    logic              done;
    logic              active;
    logic              shifting;

    spi_pf_regs #(
        .DATA_W (DATA_W),
        .GAP_W  (GAP_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .busy_i      (active),
        .take_i      (take),
        .hold_data_o (hold_data),
        .hold_full_o (hold_full),
        .buf_en_o    (buf_en),
        .gap_o       (gap_val),
        .go_o        (go)
    );

    spi_pf_seq #(
        .DATA_W  (DATA_W),
        .CLK_DIV (CLK_DIV),
        .GAP_W   (GAP_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_full_i (hold_full),
        .buf_en_i    (buf_en),
        .go_i        (go),
        .gap_i       (gap_val),
        .take_o      (take),
        .rise_o      (rise),
        .fall_o      (fall),
        .done_o      (done),
        .active_o    (active),
        .shifting_o  (shifting)
    );

    spi_pf_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (take),
        .load_data_i (hold_data),
        .rise_i      (rise),
        .fall_i      (fall),
        .done_i      (done),
        .active_i    (active),
        .shifting_i  (shifting),
        .miso_i      (spi_miso),
        .sclk_o      (spi_sclk),
        .mosi_o      (spi_mosi),
        .rx_data_o   (rx_data)
    );

    // Status and slave-select outputs.
    assign tx_full  = hold_full;
    assign tx_empty = !hold_full;
    assign busy     = active;
    assign spi_ss_n = !active;

    AST_START_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(buf_en || go)); // R6

endmodule

// File: tb/spi_prefetch_master_tb.sv
// Self-checking bench: a behavioural reference model is stepped on every rising
// edge, and all outputs are compared with it on every falling edge. Directed
// checks cover the counts and boundaries named in the requirements.
module spi_prefetch_master_tb;

    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       spi_miso = 1'b0;
    logic       tx_empty, tx_full, busy, spi_sclk, spi_mosi, spi_ss_n;
    logic [7:0] rx_data;

    int n_chk  = 0;
    int n_fail = 0;
    int busy_cyc = 0;
    logic [7:0] cap = 8'h00;
    logic [7:0] slv_pat = 8'h00;
    logic       prev_sclk = 1'b0;

    // reference model state
    int m_mode = 0;
    int m_k = 0;
    int m_gap = 0;
    bit m_full = 0;
    bit m_buf = 0;
    logic [7:0] m_hold = 8'h00, m_word = 8'h00, m_rxacc = 8'h00, m_rxout = 8'h00;
    logic [3:0] m_n = 4'h0;

    always #2 clk = ~clk;

    spi_prefetch_master #(.DATA_W(8), .CLK_DIV(DIV), .GAP_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tx_empty(tx_empty), .tx_full(tx_full), .busy(busy), .rx_data(rx_data),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ss_n(spi_ss_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ctrl(input bit go, input bit bufm, input int n);
        return {2'b00, 4'(n), bufm, go};
    endfunction

    // Reference model, one step per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_k = 0; m_gap = 0; m_full = 0; m_buf = 0;
            m_hold = 0; m_word = 0; m_rxacc = 0; m_rxout = 0; m_n = 0;
        end else begin
            bit acc, go, ctl;
            acc = wr_en && !wr_addr && !m_full && (m_buf || m_mode == 0);
            ctl = wr_en && wr_addr;
            go  = ctl && wr_data[0];
            case (m_mode)
                0: if (m_full && (m_buf || go)) begin
                       m_word = m_hold; m_full = 0; m_mode = 1; m_k = 0;
                   end
                1: begin
                       if (m_k % DIV == HALF - 1) m_rxacc = {m_rxacc[6:0], spi_miso};
                       if (m_k == 8 * DIV - 1) begin
                           m_rxout = m_rxacc;
                           if (m_buf && m_full) begin
                               m_word = m_hold; m_full = 0; m_mode = 2;
                               m_gap = (int'(m_n) + 2) * DIV;
                           end else m_mode = 0;
                       end else m_k++;
                   end
                default: begin
                       m_gap--;
                       if (m_gap == 0) begin m_mode = 1; m_k = 0; end
                   end
            endcase
            if (acc) begin m_hold = wr_data; m_full = 1; end
            if (ctl) begin m_buf = wr_data[1]; m_n = wr_data[5:2]; end
        end
    end

    // Slave side: drive MISO, capture MOSI at rising SCLK, count busy cycles.
    always @(negedge clk) begin
        spi_miso <= (m_mode == 1) ? slv_pat[7 - m_k / DIV] : 1'b0;
        if (spi_sclk && !prev_sclk) cap <= {cap[6:0], spi_mosi};
        prev_sclk <= spi_sclk;
        if (busy) busy_cyc++;
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_sclk, e_mosi;
            e_sclk = (m_mode == 1) && ((m_k % DIV) >= HALF);
            e_mosi = (m_mode == 0) ? 1'b0 : (m_mode == 1) ? m_word[7 - m_k / DIV] : m_word[7];
            chk((m_mode == 2) ? "R8 sclk in gap" : "R4 sclk", spi_sclk, e_sclk);
            chk((m_mode == 2) ? "R8 mosi in gap" : "R4 mosi", spi_mosi, e_mosi);
            chk("R9 busy", busy, m_mode != 0);
            chk("R4 ss_n", spi_ss_n, m_mode == 0);
            chk("R2 tx_full", tx_full, m_full);
            chk("R2 tx_empty", tx_empty, !m_full);
            chk("R5 rx_data", rx_data, m_rxout);
        end
    end

    task automatic wr(input bit addr, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_when_free(input logic [7:0] d);
        while (tx_full) @(negedge clk);
        wr(1'b0, d);
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ss_n", spi_ss_n, 1); chk("R1 sclk", spi_sclk, 0);
        chk("R1 mosi", spi_mosi, 0); chk("R1 busy", busy, 0);
        chk("R1 empty", tx_empty, 1); chk("R1 full", tx_full, 0);
        chk("R1 rx", rx_data, 0);

        // R2 / R3 / R4 / R5: single-shot transfer
        wr(1'b0, 8'hA5);
        chk("R2 full after write", tx_full, 1);
        wr(1'b0, 8'h3C);
        repeat (5) @(negedge clk);
        chk("R3 no start without go", busy, 0);
        slv_pat = 8'h96; busy_cyc = 0;
        wr(1'b1, ctrl(1, 0, 0));
        chk("R3 busy after go", busy, 1);
        wr(1'b0, 8'h11);
        chk("R3 write while busy ignored", tx_full, 0);
        wait_idle();
        chk("R2 held byte unchanged", cap, 8'hA5);
        chk("R4 transfer length", busy_cyc, 8 * DIV);
        chk("R5 received byte", rx_data, 8'h96);

        // R6 / R7 / R8 / R9: buffered chain of two, N=3
        wr(1'b0, 8'h5A);
        busy_cyc = 0; slv_pat = 8'h3B;
        wr(1'b1, ctrl(0, 1, 3));
        chk("R6 not yet busy", busy, 0);
        @(negedge clk);
        chk("R6 starts next cycle", busy, 1);
        repeat (3) @(negedge clk);
        wr(1'b0, 8'hC3);
        chk("R7 held during transfer", tx_full, 1);
        wait_idle();
        chk("R8 chain busy length N=3", busy_cyc, 2 * 8 * DIV + 5 * DIV);
        chk("R7 second byte sent", cap, 8'hC3);
        chk("R9 idle busy", busy, 0);
        chk("R9 idle ss_n", spi_ss_n, 1);
        chk("R5 received byte chain", rx_data, 8'h3B);

        // R8 boundary N=0
        wr(1'b1, ctrl(0, 1, 0));
        busy_cyc = 0;
        wr_when_free(8'h81);
        wr_when_free(8'h7E);
        wait_idle();
        chk("R8 chain busy length N=0", busy_cyc, 2 * 8 * DIV + 2 * DIV);

        // R8 boundary N=15, three bytes
        wr(1'b1, ctrl(0, 1, 15));
        busy_cyc = 0;
        wr_when_free(8'h01);
        wr_when_free(8'h80);
        wr_when_free(8'hF0);
        wait_idle();
        chk("R8 chain busy length N=15", busy_cyc, 3 * 8 * DIV + 2 * 17 * DIV);
        chk("R8 third byte", cap, 8'hF0);

        // R10: go bit has no effect in buffered mode
        wr(1'b1, ctrl(0, 1, 2));
        busy_cyc = 0;
        wr_when_free(8'h66);
        repeat (6) @(negedge clk);
        wr(1'b1, ctrl(1, 1, 2));
        wait_idle();
        chk("R10 go during transfer", busy_cyc, 8 * DIV);
        wr(1'b1, ctrl(1, 1, 2));
        repeat (3) @(negedge clk);
        chk("R10 go with empty buffer", busy, 0);

        // R11: clearing buffered mode stops the chain
        wr(1'b1, ctrl(0, 1, 1));
        busy_cyc = 0;
        wr_when_free(8'h24);
        wr_when_free(8'hDB);
        wr(1'b1, ctrl(0, 0, 1));
        wait_idle();
        chk("R11 chain stopped", busy_cyc, 8 * DIV);
        chk("R11 byte still held", tx_full, 1);
        wr(1'b1, ctrl(1, 0, 1));
        wait_idle();
        chk("R11 held byte sent by go", cap, 8'hDB);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule